// File: doc/BRIEF.md
# Display Bridge Bring-Up Sequencer

This block is a finite-state machine that takes a parallel-to-serial display bridge from power-on to streaming video. It does not move any bits on the serial control link itself. Instead, it hands one register access at a time (read or write, 8-bit address, 16-bit word) to a separate register access master and waits for that master's acknowledge before it moves on.

A run starts on a `start` pulse and goes through these phases in order:

- It pulses the bridge reset pin.
- When a read-back path exists, it checks two identity values.
- It writes the video timing, pixel format, lane count and base configuration.
- It writes the PLL word, virtual channel, clock divider and PLL enable, then waits for the PLL to lock.
- It sends the two panel commands, each followed by a programmable pause.
- Last, it switches the data lanes to high speed and turns on the video pipeline.

The timing values, PLL word and divider arrive already computed. They are written out unchanged. Every wait is counted in microsecond ticks from one shared prescaler, so the timing scales with the clock frequency, which is set by a parameter.

Top module: `dbb_bringup_seq`

## Requirements
- R1: While idle, `bridge_rst_n` is high. After `start` it is driven low for RESET_MS milliseconds, then released. No access is requested until a further RESET_MS milliseconds have passed.
- R2: With `rd_avail` high, two reads come first. Address 0xB0 must return 0x2828 and address 0xB7 must return 0x0301. Any mismatch ends the run with `error` high and no write issued. With `rd_avail` low, no read is ever issued.
- R3: The writes go out in this fixed address order: B1, B2, B3, B4, B5, B6, DE, B7, BA, B8, BB, B9, BC, BF, BC, BF, B7.
- R4: Timing words are packed with the vertical value in bits 15:8 and the horizontal value in bits 7:0, sums truncated to 8 bits:
  - B1 = {vsync, hsync}
  - B2 = {vsync+vbp, hsync+hbp}
  - B3 = {vfp, hfp}
  - B4 = horizontal active
  - B5 = vertical active
- R5: B6 = 0x0008 OR the 2-bit format code (0: 16 bpp, 1: packed 18 bpp, 2: loose 18 bpp, 3: 24 bpp). DE = lane count minus one.
- R6: The first write to B7 is 0x0342, with bit 5 (pixel clock as reference) also set when `ref_khz` is zero. That gives 0x0362.
- R7: BA receives `pll_word`, B8 receives 0, BB receives `lp_div` and B9 receives 1. At least LOCK_US microseconds pass before the next access.
- R8: Each panel command is a write of 1 to BC followed by the command byte to BF. Exit-sleep (0x11) is followed by a `sleep_ms` pause. Display-on (0x29) is followed by an `on_ms` pause.
- R9: The last write sets B7 to the first B7 value OR 0x0009 (bit 0 high-speed data, bit 3 video on). `done` rises the cycle after that write is acknowledged.
- R10: While `acc_req` is high and unacknowledged, `acc_rd`, `acc_addr` and `acc_wdata` hold steady. Each acknowledge completes exactly one access.
- R11: `done` and `error` are never high together. Each holds until the next `start`. A `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (from idle, done or error) |
| rd_avail | input | 1 | Read-back path to the bridge exists |
| ref_khz | input | 20 | Bridge transmit clock in kHz; zero selects the pixel clock |
| vsync_len | input | 8 | Vertical sync width |
| hsync_len | input | 8 | Horizontal sync width |
| vbp | input | 8 | Vertical back porch |
| hbp | input | 8 | Horizontal back porch |
| vfp | input | 8 | Vertical front porch |
| hfp | input | 8 | Horizontal front porch |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| pix_fmt | input | 2 | Pixel format code |
| lanes | input | 3 | Number of data lanes (1 to 4) |
| pll_word | input | 16 | Precomputed PLL setting |
| lp_div | input | 16 | Precomputed low-power clock divider word |
| sleep_ms | input | 8 | Pause after exit-sleep, in ms |
| on_ms | input | 8 | Pause after display-on, in ms |
| bridge_rst_n | output | 1 | Reset pin of the bridge |
| acc_req | output | 1 | Access request to the register master |
| acc_rd | output | 1 | Access is a read |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | One-cycle acknowledge from the master |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| done | output | 1 | Bring-up finished |
| error | output | 1 | Read-back check failed |

## Verification
The assertions rely on three things about the environment:
- Every input other than `start`, `acc_ack` and `acc_rdata` stays constant for the whole of a run.
- `acc_ack` is only raised while `acc_req` is high.
- Read data is sampled only together with that acknowledge.

The bench keeps to this by drawing a new random parameter set only between runs, while the bench is idle. Its register master model acknowledges after a random delay of zero to two cycles, and only while a request is pending. Directed runs cover both read-back failures, the pixel-clock reference and an extra `start` issued while a run is in progress.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NSTEPS = 17;
  localparam int SW = $clog2(NSTEPS);

  // register addresses on the bridge
  localparam logic [AW-1:0] A_ID     = 8'hB0;
  localparam logic [AW-1:0] A_SYNC   = 8'hB1;
  localparam logic [AW-1:0] A_BACK   = 8'hB2;
  localparam logic [AW-1:0] A_FRONT  = 8'hB3;
  localparam logic [AW-1:0] A_HACT   = 8'hB4;
  localparam logic [AW-1:0] A_VACT   = 8'hB5;
  localparam logic [AW-1:0] A_FMT    = 8'hB6;
  localparam logic [AW-1:0] A_CFG    = 8'hB7;
  localparam logic [AW-1:0] A_VCH    = 8'hB8;
  localparam logic [AW-1:0] A_PLLON  = 8'hB9;
  localparam logic [AW-1:0] A_PLLW   = 8'hBA;
  localparam logic [AW-1:0] A_CKDIV  = 8'hBB;
  localparam logic [AW-1:0] A_PKTLEN = 8'hBC;
  localparam logic [AW-1:0] A_PAYLD  = 8'hBF;
  localparam logic [AW-1:0] A_LANES  = 8'hDE;

  localparam logic [DW-1:0] ID_WORD = 16'h2828;
  localparam logic [DW-1:0] CFG_POR = 16'h0301;

  // configuration bit positions
  localparam int CB_HSDATA = 0;
  localparam int CB_CLKHS  = 1;
  localparam int CB_VIDEO  = 3;
  localparam int CB_PCLK   = 5;
  localparam int CB_CMDONLY = 6;

  localparam logic [DW-1:0] BURST_MODE = 16'h0008;
  localparam logic [7:0] CMD_WAKE = 8'h11;
  localparam logic [7:0] CMD_SHOW = 8'h29;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_LOCK = 2'd1,
    W_WAKE = 2'd2,
    W_SHOW = 2'd3
  } pause_e;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_RSTLO = 4'd1,
    S_RSTHI = 4'd2,
    S_RDID  = 4'd3,
    S_RDCFG = 4'd4,
    S_WR    = 4'd5,
    S_PAUSE = 4'd6,
    S_DONE  = 4'd7,
    S_ERR   = 4'd8
  } state_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    pause_e        pause;
    logic          last;
  } step_t;

endpackage

// File: rtl/dbb_us_tick.sv
module dbb_us_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  generate
    if (CYC_PER_US <= 1) begin : g_every
      logic unused_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unused_q <= 1'b0;
        else        unused_q <= clr;
      end
      assign tick = 1'b1;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;
      assign wrap = (cnt_q == LAST);
      always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign tick = wrap && !clr;
    end
  endgenerate
endmodule

// File: rtl/dbb_wait_timer.sv
module dbb_wait_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [TW-1:0] rem_q, rem_d;
  logic          rem_en;

  assign zero   = (rem_q == '0);
  assign rem_en = load || (tick && !zero);

  always_comb begin
    if (load) rem_d = load_val;
    else      rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/dbb_step_gen.sv
module dbb_step_gen
  import dbb_pkg::*;
(
  input  logic [SW-1:0] idx,
  input  logic          pclk_ref,
  input  logic [7:0]    vsync_len,
  input  logic [7:0]    hsync_len,
  input  logic [7:0]    vbp,
  input  logic [7:0]    hbp,
  input  logic [7:0]    vfp,
  input  logic [7:0]    hfp,
  input  logic [15:0]   h_active,
  input  logic [15:0]   v_active,
  input  logic [1:0]    pix_fmt,
  input  logic [2:0]    lanes,
  input  logic [15:0]   pll_word,
  input  logic [15:0]   lp_div,
  output step_t         step
);
  logic [DW-1:0] cfg_lp;
  logic [DW-1:0] cfg_hs;
  logic [7:0]    vtot;
  logic [7:0]    htot;
  logic [2:0]    lane_code;

  always_comb begin
    cfg_lp = CFG_POR;
    cfg_lp[CB_HSDATA]  = 1'b0;
    cfg_lp[CB_CLKHS]   = 1'b1;
    cfg_lp[CB_CMDONLY] = 1'b1;
    cfg_lp[CB_PCLK]    = pclk_ref;
    cfg_hs = cfg_lp;
    cfg_hs[CB_HSDATA]  = 1'b1;
    cfg_hs[CB_VIDEO]   = 1'b1;
  end

  assign vtot      = vsync_len + vbp;
  assign htot      = hsync_len + hbp;
  assign lane_code = lanes - 3'd1;

  always_comb begin
    step = '{addr: A_ID, data: '0, pause: W_NONE, last: 1'b0};
    case (idx)
      SW'(0):  begin step.addr = A_SYNC;   step.data = {vsync_len, hsync_len}; end
      SW'(1):  begin step.addr = A_BACK;   step.data = {vtot, htot}; end
      SW'(2):  begin step.addr = A_FRONT;  step.data = {vfp, hfp}; end
      SW'(3):  begin step.addr = A_HACT;   step.data = h_active; end
      SW'(4):  begin step.addr = A_VACT;   step.data = v_active; end
      SW'(5):  begin step.addr = A_FMT;    step.data = BURST_MODE | {14'd0, pix_fmt}; end
      SW'(6):  begin step.addr = A_LANES;  step.data = {13'd0, lane_code}; end
      SW'(7):  begin step.addr = A_CFG;    step.data = cfg_lp; end
      SW'(8):  begin step.addr = A_PLLW;   step.data = pll_word; end
      SW'(9):  begin step.addr = A_VCH;    step.data = '0; end
      SW'(10): begin step.addr = A_CKDIV;  step.data = lp_div; end
      SW'(11): begin step.addr = A_PLLON;  step.data = 16'd1; step.pause = W_LOCK; end
      SW'(12): begin step.addr = A_PKTLEN; step.data = 16'd1; end
      SW'(13): begin step.addr = A_PAYLD;  step.data = {8'd0, CMD_WAKE}; step.pause = W_WAKE; end
      SW'(14): begin step.addr = A_PKTLEN; step.data = 16'd1; end
      SW'(15): begin step.addr = A_PAYLD;  step.data = {8'd0, CMD_SHOW}; step.pause = W_SHOW; end
      SW'(16): begin step.addr = A_CFG;    step.data = cfg_hs; step.last = 1'b1; end
      default: step.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbb_bringup_seq.sv
module dbb_bringup_seq
  import dbb_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int RESET_MS   = 10,
  parameter int LOCK_US    = 500,
  parameter int REF_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_avail,
  input  logic [REF_W-1:0] ref_khz,
  input  logic [7:0]       vsync_len,
  input  logic [7:0]       hsync_len,
  input  logic [7:0]       vbp,
  input  logic [7:0]       hbp,
  input  logic [7:0]       vfp,
  input  logic [7:0]       hfp,
  input  logic [15:0]      h_active,
  input  logic [15:0]      v_active,
  input  logic [1:0]       pix_fmt,
  input  logic [2:0]       lanes,
  input  logic [15:0]      pll_word,
  input  logic [15:0]      lp_div,
  input  logic [7:0]       sleep_ms,
  input  logic [7:0]       on_ms,
  output logic             bridge_rst_n,
  output logic             acc_req,
  output logic             acc_rd,
  output logic [7:0]       acc_addr,
  output logic [15:0]      acc_wdata,
  input  logic             acc_ack,
  input  logic [15:0]      acc_rdata,
  output logic             done,
  output logic             error
);
  localparam int TW = 32;
  localparam logic [TW-1:0] RST_US  = TW'(RESET_MS * US_PER_MS);
  localparam logic [TW-1:0] LOCK_T  = TW'(LOCK_US);
  localparam logic [TW-1:0] MS_US   = TW'(US_PER_MS);

  state_e        state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          step_en;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          us_tick;
  step_t         cur;
  logic          pclk_ref;

  assign pclk_ref = (ref_khz == '0);

  dbb_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tmr_load), .tick(us_tick)
  );

  dbb_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(us_tick), .zero(tmr_zero)
  );

  dbb_step_gen u_steps (
    .idx(step_q), .pclk_ref(pclk_ref),
    .vsync_len(vsync_len), .hsync_len(hsync_len), .vbp(vbp), .hbp(hbp),
    .vfp(vfp), .hfp(hfp), .h_active(h_active), .v_active(v_active),
    .pix_fmt(pix_fmt), .lanes(lanes), .pll_word(pll_word), .lp_div(lp_div),
    .step(cur)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    step_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          state_d  = S_RSTLO;
          tmr_load = 1'b1;
          tmr_val  = RST_US;
        end
      end
      S_RSTLO: begin
        if (tmr_zero) begin
          state_d  = S_RSTHI;
          tmr_load = 1'b1;
          tmr_val  = RST_US;
        end
      end
      S_RSTHI: begin
        if (tmr_zero) begin
          step_en = 1'b1;
          step_d  = '0;
          state_d = rd_avail ? S_RDID : S_WR;
        end
      end
      S_RDID: begin
        if (acc_ack) state_d = (acc_rdata == ID_WORD) ? S_RDCFG : S_ERR;
      end
      S_RDCFG: begin
        if (acc_ack) state_d = (acc_rdata == CFG_POR) ? S_WR : S_ERR;
      end
      S_WR: begin
        if (acc_ack) begin
          step_en = 1'b1;
          step_d  = step_q + 1'b1;
          if (cur.last) begin
            state_d = S_DONE;
          end else if (cur.pause != W_NONE) begin
            state_d  = S_PAUSE;
            tmr_load = 1'b1;
            case (cur.pause)
              W_LOCK:  tmr_val = LOCK_T;
              W_WAKE:  tmr_val = TW'(sleep_ms) * MS_US;
              default: tmr_val = TW'(on_ms) * MS_US;
            endcase
          end
        end
      end
      S_PAUSE: begin
        if (tmr_zero) state_d = S_WR;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
    end
  end

  // outputs
  always_comb begin
    acc_req   = 1'b0;
    acc_rd    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    case (state_q)
      S_RDID:  begin acc_req = 1'b1; acc_rd = 1'b1; acc_addr = A_ID; end
      S_RDCFG: begin acc_req = 1'b1; acc_rd = 1'b1; acc_addr = A_CFG; end
      S_WR:    begin acc_req = 1'b1; acc_addr = cur.addr; acc_wdata = cur.data; end
      default: ;
    endcase
  end

  assign bridge_rst_n = (state_q != S_RSTLO);
  assign done         = (state_q == S_DONE);
  assign error        = (state_q == S_ERR);

endmodule

// File: rtl/dbb_bringup_seq_chk.sv
module dbb_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_avail,
  input logic        bridge_rst_n,
  input logic        acc_req,
  input logic        acc_rd,
  input logic [7:0]  acc_addr,
  input logic [15:0] acc_wdata,
  input logic        acc_ack,
  input logic        done,
  input logic        error
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !acc_req); // R1

  AST_ERR_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> rd_avail && $past(acc_rd) && $past(acc_ack)); // R2

  AST_FINAL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ack && !acc_rd && acc_addr == 8'hB7 && acc_wdata[3] |=> done); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_ack |=> acc_req && $stable(acc_rd) && $stable(acc_addr)
                            && $stable(acc_wdata)); // R10

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R11

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R11

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error); // R11
endmodule

bind dbb_bringup_seq dbb_bringup_seq_chk u_chk (.*);

// File: tb/dbb_bringup_seq_test.sv
`timescale 1ns/1ps
module dbb_bringup_seq_test;
  localparam int CPU = 2;
  localparam int UPM = 5;
  localparam int RMS = 10;
  localparam int LUS = 20;
  localparam int RST_CYC = RMS * UPM * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_avail = 1'b0;
  logic [19:0] ref_khz = 20'd1000;
  logic [7:0] vs = 0, hs = 0, vbp = 0, hbp = 0, vfp = 0, hfp = 0;
  logic [15:0] hact = 0, vact = 0, pll = 0, div = 0;
  logic [1:0] fmt = 0;
  logic [2:0] lanes = 3'd1;
  logic [7:0] slp = 0, onm = 0;
  logic bridge_rst_n, acc_req, acc_rd, done, error;
  logic [7:0] acc_addr;
  logic [15:0] acc_wdata;
  logic acc_ack = 1'b0;
  logic [15:0] acc_rdata = 16'd0;
  logic [15:0] id_val = 16'h2828, cfg_val = 16'h0301;

  int checks = 0, fails = 0, cyc = 0;
  int log_n = 0;
  logic [7:0]  log_addr [0:31];
  logic [15:0] log_data [0:31];
  logic        log_rd   [0:31];
  int          log_cyc  [0:31];
  int exp_n;
  logic [7:0]  exp_addr [0:31];
  logic [15:0] exp_data [0:31];
  logic        exp_rd   [0:31];
  string       exp_tag  [0:31];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbb_bringup_seq #(.CYC_PER_US(CPU), .US_PER_MS(UPM), .RESET_MS(RMS), .LOCK_US(LUS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_avail(rd_avail), .ref_khz(ref_khz),
    .vsync_len(vs), .hsync_len(hs), .vbp(vbp), .hbp(hbp), .vfp(vfp), .hfp(hfp),
    .h_active(hact), .v_active(vact), .pix_fmt(fmt), .lanes(lanes),
    .pll_word(pll), .lp_div(div), .sleep_ms(slp), .on_ms(onm),
    .bridge_rst_n(bridge_rst_n), .acc_req(acc_req), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_rdata(acc_rdata), .done(done), .error(error)
  );

  // register access master model: random 0..2 cycle latency
  initial begin
    int lat;
    bit pend;
    lat = 0; pend = 0;
    forever begin
      @(negedge clk);
      acc_ack = 1'b0;
      if (rst_n && acc_req) begin
        if (!pend) begin lat = int'($urandom % 3); pend = 1; end
        if (lat == 0) begin
          acc_ack = 1'b1;
          acc_rdata = (acc_addr == 8'hB0) ? id_val : cfg_val;
          if (log_n < 32) begin
            log_addr[log_n] = acc_addr;
            log_data[log_n] = acc_wdata;
            log_rd[log_n]   = acc_rd;
            log_cyc[log_n]  = cyc;
          end
          log_n++;
          pend = 0;
        end else lat--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic add_exp(input logic [7:0] a, input logic [15:0] d, input logic r,
                         input string t);
    exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_rd[exp_n] = r; exp_tag[exp_n] = t;
    exp_n++;
  endtask

  task automatic build_exp(input bit rd, input bit id_ok, input bit cfg_ok);
    logic [15:0] c1;
    logic [7:0] sv, sh;
    c1 = (ref_khz == 0) ? 16'h0362 : 16'h0342;
    sv = vs + vbp;
    sh = hs + hbp;
    exp_n = 0;
    if (rd) begin
      add_exp(8'hB0, 16'h0, 1'b1, "R2");
      if (!id_ok) return;
      add_exp(8'hB7, 16'h0, 1'b1, "R2");
      if (!cfg_ok) return;
    end
    add_exp(8'hB1, {vs, hs}, 1'b0, "R4");
    add_exp(8'hB2, {sv, sh}, 1'b0, "R4");
    add_exp(8'hB3, {vfp, hfp}, 1'b0, "R4");
    add_exp(8'hB4, hact, 1'b0, "R4");
    add_exp(8'hB5, vact, 1'b0, "R4");
    add_exp(8'hB6, 16'h0008 | {14'd0, fmt}, 1'b0, "R5");
    add_exp(8'hDE, {13'd0, lanes - 3'd1}, 1'b0, "R5");
    add_exp(8'hB7, c1, 1'b0, "R6");
    add_exp(8'hBA, pll, 1'b0, "R7");
    add_exp(8'hB8, 16'h0, 1'b0, "R7");
    add_exp(8'hBB, div, 1'b0, "R7");
    add_exp(8'hB9, 16'h1, 1'b0, "R7");
    add_exp(8'hBC, 16'h1, 1'b0, "R8");
    add_exp(8'hBF, 16'h11, 1'b0, "R8");
    add_exp(8'hBC, 16'h1, 1'b0, "R8");
    add_exp(8'hBF, 16'h29, 1'b0, "R8");
    add_exp(8'hB7, c1 | 16'h0009, 1'b0, "R9");
  endtask

  task automatic randomize_params(input logic [1:0] f, input bit pclk);
    vs = 8'($urandom); hs = 8'($urandom); vbp = 8'($urandom); hbp = 8'($urandom);
    vfp = 8'($urandom); hfp = 8'($urandom);
    hact = 16'($urandom); vact = 16'($urandom);
    pll = 16'($urandom); div = 16'($urandom);
    fmt = f;
    lanes = 3'(1 + ($urandom % 4));
    slp = 8'($urandom % 4); onm = 8'($urandom % 4);
    ref_khz = pclk ? 20'd0 : 20'(1 + ($urandom % 50000));
  endtask

  task automatic do_run(input bit rd, input bit id_ok, input bit cfg_ok, input bit mid_start);
    int rst_low, rst_rise, fin_cyc, fin;
    logic prev_rst;
    rd_avail = rd;
    id_val  = id_ok ? 16'h2828 : 16'h2829;
    cfg_val = cfg_ok ? 16'h0301 : 16'h0300;
    build_exp(rd, id_ok, cfg_ok);
    rst_low = 0; rst_rise = -1; fin_cyc = -1; fin = 0; prev_rst = 1'b1;
    @(negedge clk); log_n = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      start = (mid_start && k == 20) ? 1'b1 : 1'b0;  // R11 stray start
      if (!bridge_rst_n) rst_low++;
      else if (!prev_rst && rst_rise < 0) rst_rise = cyc;
      prev_rst = bridge_rst_n;
      if (done || error) begin fin = 1; fin_cyc = cyc; break; end
    end
    start = 1'b0;
    check(fin == 1, "R11", "watchdog: run finished", fin, 1);
    // R1 reset low width and settle time
    check(rst_low >= RST_CYC && rst_low <= RST_CYC + 2, "R1", "reset low cycles",
          rst_low, RST_CYC);
    if (log_n > 0)
      check(log_cyc[0] - rst_rise >= RST_CYC, "R1", "settle before first access",
            log_cyc[0] - rst_rise, RST_CYC);
    // R3 / R10: one log entry per acknowledge, in order
    check(log_n == exp_n, "R3", "access count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_addr[i] == exp_addr[i], "R3", $sformatf("address of access %0d", i),
            log_addr[i], exp_addr[i]);
      check(log_rd[i] == exp_rd[i], "R2", $sformatf("read flag of access %0d", i),
            log_rd[i], exp_rd[i]);
      if (!exp_rd[i])
        check(log_data[i] == exp_data[i], exp_tag[i], $sformatf("data of access %0d", i),
              log_data[i], exp_data[i]);
    end
    if (!rd) for (int i = 0; i < log_n && i < 32; i++)
      check(log_rd[i] == 1'b0, "R2", "no read without read-back", log_rd[i], 0);
    if (rd && (!id_ok || !cfg_ok)) begin
      check(error == 1'b1 && done == 1'b0, "R2", "error flag after mismatch",
            {done, error}, 2'b01);
    end else begin
      check(done == 1'b1 && error == 1'b0, "R9", "done flag", {done, error}, 2'b10);
      if (log_n == exp_n) begin
        int b;
        b = exp_n - 17;
        check(log_cyc[b+12] - log_cyc[b+11] >= LUS * CPU, "R7", "PLL lock wait",
              log_cyc[b+12] - log_cyc[b+11], LUS * CPU);
        check(log_cyc[b+14] - log_cyc[b+13] >= int'(slp) * UPM * CPU, "R8",
              "exit-sleep pause", log_cyc[b+14] - log_cyc[b+13], int'(slp) * UPM * CPU);
        check(fin_cyc - log_cyc[b+15] >= int'(onm) * UPM * CPU, "R8",
              "display-on pause", fin_cyc - log_cyc[b+15], int'(onm) * UPM * CPU);
      end
    end
    // R11: flag holds without start
    repeat (5) @(negedge clk);
    check((done | error) == 1'b1 && !(done && error), "R11", "flag held after run",
          {done, error}, 0);
    check(acc_req == 1'b0 && bridge_rst_n == 1'b1, "R11", "quiet after run",
          {acc_req, bridge_rst_n}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && error == 0, "R11", "reset flags", {done, error}, 0);
    check(acc_req == 0, "R10", "reset request", acc_req, 0);
    check(bridge_rst_n == 1, "R1", "reset pin high when idle", bridge_rst_n, 1);

    randomize_params(2'd0, 1'b0); do_run(1'b0, 1'b1, 1'b1, 1'b0);
    randomize_params(2'd1, 1'b1); do_run(1'b1, 1'b1, 1'b1, 1'b0);  // R6 pixel clock
    randomize_params(2'd2, 1'b0); do_run(1'b1, 1'b0, 1'b1, 1'b0);  // R2 bad id
    randomize_params(2'd3, 1'b0); do_run(1'b1, 1'b1, 1'b0, 1'b0);  // R2 bad cfg
    randomize_params(2'd2, 1'b0); do_run(1'b0, 1'b1, 1'b1, 1'b1);  // R11 stray start
    slp = 0;
    for (int i = 0; i < 5; i++) begin
      randomize_params(2'(i), ($urandom % 3) == 0);
      if (i == 0) begin slp = 0; onm = 0; lanes = 3'd4; end  // zero pauses
      do_run(1'($urandom % 2), 1'b1, 1'b1, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule